// File: doc/BRIEF.md
# BERT Received-Bit Counter with Snapshot Register

This block counts the data bits a bit-error-rate tester has received during a measurement window. A strobe marks each received bit, and a flag from the pattern checker reports receive synchronization. Counting is armed the first time the sync flag is seen high. Once armed, the counter keeps running even if sync later drops. The count saturates at all ones instead of wrapping, and the first arrival at that value raises a sticky overflow flag.

The host frames a measurement window by raising a latch-control bit. Each rising edge of that bit, after it has been registered, copies the running count into a 32-bit holding register and clears the counter. If sync is high at that moment, counting restarts from zero at once. If sync is low, the counter stays at zero until sync returns. The host reads the holding register one byte at a time through a small synchronous read port. The overflow flag stays set until the host pulses its clear input.

Top module: `bert_bitcount_top`

## Requirements
- R1: While counting is enabled, each cycle with `bit_vld` high adds exactly one to the running count. The counter is `CNT_W` bits wide, 32 by default.
- R2: After reset, no strobe is counted until `rx_sync` has been sampled high. A strobe in the same cycle that `rx_sync` is first high is counted.
- R3: Once armed, the counter keeps counting strobes even while `rx_sync` is low.
- R4: The count stops at the all-ones value. Further strobes leave it unchanged, and it never rolls over to zero.
- R5: `ovf_flag` goes high on the same clock edge at which the count reaches all ones. It is low while the count is below that value.
- R6: A 0-to-1 transition of `latch_ctl` is registered, and on the following edge the running count is copied into the holding register, zero-extended to 32 bits, and the counter is cleared. A strobe in the cycle when the transition is acted on is counted into the new window, not into the snapshot.
- R7: If `rx_sync` is high when the snapshot is taken, the counter stays armed and counts up from zero immediately.
- R8: If `rx_sync` is low when the snapshot is taken, the counter is disarmed and held at zero until `rx_sync` is high again.
- R9: The read port returns holding-register bits 7:0, 15:8, 23:16 and 31:24 for `rd_addr` 0x40, 0x41, 0x42 and 0x43. The data is registered and appears one clock after the address. Any other address reads 0x00.
- R10: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. A snapshot does not clear it. If saturation and a clear fall in the same cycle, the flag is set.
- R11: A synchronous active-low `rst_n` clears the counter, the arming state, the holding register, the overflow flag and the latch-edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | One received data bit this cycle |
| rx_sync | input | 1 | Receive synchronization flag from the pattern checker |
| latch_ctl | input | 1 | Host latch control; a rising edge snapshots and clears the count |
| ovf_clr | input | 1 | Host clear of the overflow flag (write-one strobe) |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered byte of the holding register |
| ovf_flag | output | 1 | Sticky counter-saturation flag |

## Verification
On every cycle, the embedded assertions check the following:
- the counter stays at zero while disarmed;
- it increments by one for each armed strobe;
- it holds at all ones;
- the overflow flag rises no later than saturation and stays set until cleared;
- every snapshot equals the count of the previous cycle, and the restart value follows `rx_sync` and `bit_vld`.

Only the bench scenarios can show the rest:
- the whole window story: sync arriving late, sync lost mid-window, and re-arming after a sync-low latch;
- the byte-lane mapping and registered timing of the read port;
- the full saturation run;
- that a bit in the edge cycle goes to the next window and not the current one.

// File: rtl/bert_bc_pkg.sv
// Package: shared constants for the BERT received-bit counter.
// Assumes: the holding register is always 32 bits and is read in bytes.
package bert_bc_pkg;
    localparam int HOLD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int NUM_LANES = HOLD_W / BYTE_W;

    typedef logic [HOLD_W-1:0] hold_word_t;
    typedef logic [BYTE_W-1:0] rd_byte_t;
endpackage

// File: rtl/bc_ctl_edge.sv
// Module: bc_ctl_edge
// Registers the host latch-control bit and produces a one-cycle pulse
// when the registered copy moves from 0 to 1.
// Assumes: latch_ctl_i is synchronous to clk (the host port is synchronous).
module bc_ctl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_ctl_i,
    output logic edge_o
);
    logic ctl_q;
    logic ctl_prev_q;

    // Purpose: keep the registered control bit and its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q      <= 1'b0;
            ctl_prev_q <= 1'b0;
        end else begin
            ctl_q      <= latch_ctl_i;
            ctl_prev_q <= ctl_q;
        end
    end

    // Purpose: rising-edge pulse of the registered control bit.
    always_comb begin
        edge_o = ctl_q & ~ctl_prev_q;
    end

    // R6: the edge pulse never lasts two cycles in a row.
    a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/bc_sat_counter.sv
// Module: bc_sat_counter
// Sync-gated saturating bit counter with its arming state and the sticky
// overflow flag. A snapshot pulse clears the count; the new window starts
// armed only if sync is high at that moment.
// Assumes: edge_i is a single-cycle pulse from bc_ctl_edge.
module bc_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld_i,
    input  logic             rx_sync_i,
    input  logic             edge_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             armed_q, armed_d;
    logic             ovf_q;
    logic             set_ovf;
    logic             at_max;
    logic             count_en;

    // Purpose: decode saturation and the counting enable.
    always_comb begin
        at_max   = (cnt_q == CNT_MAX);
        count_en = (armed_q | rx_sync_i) & bit_vld_i;
    end

    // Purpose: next count, next arming state and saturation event.
    always_comb begin
        cnt_d   = cnt_q;
        armed_d = armed_q;
        set_ovf = 1'b0;
        if (edge_i) begin
            armed_d = rx_sync_i;
            cnt_d   = (rx_sync_i && bit_vld_i) ? CNT_ONE : '0;
            set_ovf = (rx_sync_i && bit_vld_i) && (CNT_ONE == CNT_MAX);
        end else begin
            armed_d = armed_q | rx_sync_i;
            if (count_en && !at_max) begin
                cnt_d   = cnt_q + CNT_ONE;
                set_ovf = (cnt_d == CNT_MAX);
            end
        end
    end

    // Purpose: count and arming registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
        end
    end

    // Purpose: sticky overflow flag; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (set_ovf) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr_i) begin
            ovf_q <= 1'b0;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R2 / R8: a disarmed counter always reads zero.
    a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (cnt_q == '0));

    // R1 / R3: an armed strobe below saturation adds exactly one.
    a_r3_keeps_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && bit_vld_i && !edge_i && (cnt_q != CNT_MAX))
            |=> (cnt_q == $past(cnt_q) + CNT_ONE));

    // R4: the saturated value never rolls over.
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == CNT_MAX) && !edge_i) |=> (cnt_q == CNT_MAX));

    // R5: reaching all ones raises the overflow flag on the same edge.
    a_r5_ovf_on_sat: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_q == CNT_MAX) |-> ovf_q);

    // R10: the flag stays set unless the host clears it.
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr_i) |=> ovf_q);

    // R7: with sync at the snapshot, a same-cycle strobe starts the new window at one.
    a_r7_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && rx_sync_i && bit_vld_i) |=> (cnt_q == CNT_ONE));

    // R8: without sync at the snapshot, the counter restarts at zero.
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && !rx_sync_i) |=> (cnt_q == '0));
endmodule

// File: rtl/bc_hold_regs.sv
// Module: bc_hold_regs
// 32-bit holding register loaded on each snapshot pulse, plus a registered
// byte read port. The byte lanes sit at BASE_ADDR .. BASE_ADDR+3, least
// significant byte first.
// Assumes: CNT_W <= 32; the count is zero-extended into the holding word.
module bc_hold_regs
    import bert_bc_pkg::*;
#(
    parameter int              CNT_W     = 32,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output rd_byte_t          rd_data_o
);
    hold_word_t hold_q;
    rd_byte_t   lane_data [NUM_LANES];
    rd_byte_t   rd_d;
    rd_byte_t   rd_q;

    // Purpose: capture the running count on a snapshot pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (edge_i) begin
            hold_q <= HOLD_W'(cnt_i);
        end
    end

    // One decoder per byte lane; unselected lanes contribute zero.
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(g);
        // Purpose: gate this lane's byte onto the read OR-tree.
        always_comb begin
            lane_data[g] = (rd_addr_i == LANE_ADDR) ? hold_q[g*BYTE_W +: BYTE_W] : '0;
        end
    end

    // Purpose: merge the lane outputs.
    always_comb begin
        rd_d = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            rd_d = rd_d | lane_data[i];
        end
    end

    // Purpose: register the read data for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

    // R6: each snapshot holds the count seen in the cycle of the pulse.
    a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (hold_q == HOLD_W'($past(cnt_i))));

    // R6: the holding word changes only on a snapshot.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_i |=> $stable(hold_q));
endmodule

// File: rtl/bert_bitcount_top.sv
// Module: bert_bitcount_top
// Received-bit counter for a bit-error-rate tester: sync-gated saturating
// count, snapshot on a latch-control rising edge, sticky overflow flag and
// byte-wide host read of the snapshot.
// Assumes: all inputs are synchronous to clk; CNT_W is between 1 and 32.
module bert_bitcount_top
    import bert_bc_pkg::*;
#(
    parameter int                CNT_W     = 32,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              rx_sync,
    input  logic              latch_ctl,
    input  logic              ovf_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ovf_flag
);
    logic             snap_edge;
    logic [CNT_W-1:0] run_cnt;

    bc_ctl_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_ctl_i (latch_ctl),
        .edge_o      (snap_edge)
    );

    bc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld_i (bit_vld),
        .rx_sync_i (rx_sync),
        .edge_i    (snap_edge),
        .ovf_clr_i (ovf_clr),
        .cnt_o     (run_cnt),
        .ovf_o     (ovf_flag)
    );

    bc_hold_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (snap_edge),
        .cnt_i     (run_cnt),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // R11: one cycle after reset, the read data and flag are zero.
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !ovf_flag));
endmodule

// File: tb/bert_bitcount_top_tb_top.sv
module bert_bitcount_top_tb_top;
    localparam int CNT_W = 12;   // narrow counter so saturation is reachable

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       rx_sync = 1'b0;
    logic       latch_ctl = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bert_bitcount_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_sync(rx_sync),
        .latch_ctl(latch_ctl), .ovf_clr(ovf_clr), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    // Vector: {sync level, strobe count, expected snapshot}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 16'd5,   16'd0},    // R2 not armed yet
        {1'b1, 16'd7,   16'd7},    // R1 armed by sync
        {1'b0, 16'd9,   16'd9},    // R3 sync lost, still counting
        {1'b0, 16'd4,   16'd0},    // R8 disarmed by sync-low latch
        {1'b1, 16'd300, 16'd300},  // R1 / R9 crosses a byte boundary
        {1'b1, 16'd0,   16'd0}     // R6 empty window
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic strobes(input int n);
        if (n > 0) begin
            bit_vld = 1'b1;
            repeat (n) @(negedge clk);
            bit_vld = 1'b0;
        end
    endtask

    task automatic do_latch();
        @(negedge clk) latch_ctl = 1'b1;
        repeat (3) @(negedge clk);
        latch_ctl = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_byte(input logic [7:0] addr, input logic [7:0] exp, input string req);
        @(negedge clk) rd_addr = addr;
        @(negedge clk) chk(req, 32'(rd_data), 32'(exp));
    endtask

    task automatic read_word(input logic [31:0] exp, input string req);
        for (int b = 0; b < 4; b++) begin
            read_byte(8'h40 + 8'(b), exp[b*8 +: 8], req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        read_word(32'h0, "R11 reset hold");
        chk("R11 reset ovf", 32'(ovf_flag), 32'h0);

        // Table walk
        for (int v = 0; v < 6; v++) begin
            rx_sync = VEC[v][32];
            @(negedge clk);
            strobes(int'(VEC[v][31:16]));
            do_latch();
            read_word(32'(VEC[v][15:0]), "R1/R2/R3/R8 vector snapshot");
        end

        // R6 / R7: strobe in the edge cycle goes into the new window
        rx_sync = 1'b1;
        strobes(5);
        @(negedge clk) latch_ctl = 1'b1;
        @(negedge clk) bit_vld = 1'b1;
        @(negedge clk) bit_vld = 1'b0;
        @(negedge clk) latch_ctl = 1'b0;
        repeat (3) @(negedge clk);
        read_word(32'd5, "R6 edge-cycle bit excluded");
        do_latch();
        read_word(32'd1, "R7 edge-cycle bit in new window");

        // R4 / R5 / R10 saturation
        strobes(4094);
        chk("R5 no ovf below max", 32'(ovf_flag), 32'h0);
        strobes(1);
        chk("R5 ovf at max", 32'(ovf_flag), 32'h1);
        strobes(10);
        do_latch();
        read_word(32'h0000_0FFF, "R4 saturated snapshot");
        chk("R10 ovf survives snapshot", 32'(ovf_flag), 32'h1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        chk("R10 ovf cleared", 32'(ovf_flag), 32'h0);

        // R9 unmapped addresses: put a nonzero value in the holding register first
        strobes(3);
        do_latch();
        read_byte(8'h40, 8'h03, "R9 low byte");
        read_byte(8'h44, 8'h00, "R9 unmapped 0x44");
        read_byte(8'h3F, 8'h00, "R9 unmapped 0x3F");

        // R11 mid-run reset clears holding register and disarms
        rx_sync = 1'b1;
        strobes(20);
        @(negedge clk) rst_n = 1'b0;
        rx_sync = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(32'h0, "R11 hold cleared");
        strobes(6);
        do_latch();
        read_word(32'h0, "R11 disarmed after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule